// File: doc/BRIEF.md
# Serial Audio Input Port

This block receives stereo PCM over a three-wire serial link made of a bit clock, a left/right word clock and a data line. It turns each channel's bits into a 24-bit parallel sample and marks the sample with a channel flag and a one-cycle valid strobe. Everything runs in one system (master) clock domain. In slave mode the two link clocks come from outside and are oversampled through synchronizers. The bit clock may then be gapped and unrelated to the system clock. In master mode the block divides the system clock and drives the bit clock and word clock itself.

Static configuration inputs control the link format. They select the clocking mode, the divide ratio, which bit-clock edge samples data, which word-clock level means left, an optional one-bit delay before the first data bit, and the justification. For right-justified framing they also select the word length. A sample is emitted at the word-clock transition that closes its channel phase. An overflow flag goes with any sample whose phase received too many bit clocks.

Top module: `sai_rx_port`

## Requirements
- R1: With `cfg_master`=0, `bclk_o` and `wclk_o` are held low and the link clocks come from `bclk_i`/`wclk_i`. With `cfg_master`=1, the block generates both clocks and ignores `bclk_i`/`wclk_i`.
- R2: In master mode, `cfg_rate` 00/01/10 (11 acts as 10) gives a bit-clock period of 4/6/8 system clocks with equal high and low times. This is 64 bit clocks per frame, i.e. 256/384/512 system clocks. The word clock holds each level for 32 bit clocks and changes only on the non-sampling bit-clock edge.
- R3: `cfg_fall_edge`=0 samples data on rising bit-clock edges; `cfg_fall_edge`=1 samples on falling edges.
- R4: `cfg_left_high`=1 means a high word clock marks the left channel; 0 means low marks left. `smp_right` is 0 for a left sample and 1 for a right sample.
- R5: `cfg_delay`=1 discards the first sampled bit of each phase in left-justified capture, which gives I2S framing.
- R6: With `cfg_rjust`=0, bits are taken MSB first into bit 23 downward. A word shorter than 24 bits is zero-padded at the bottom, and bits past the 24th are ignored.
- R7: With `cfg_rjust`=1, the sample is the last N bits sampled before the word-clock transition, sign-extended to 24 bits. `cfg_res` 00/01/10 selects N=24/20/16, and 11 acts as 24.
- R8: `smp_valid` is a single-cycle pulse, one per word-clock transition. The first transition after reset only arms the block and emits nothing. `smp_data` holds its value between pulses.
- R9: Stopping the bit clock for any time within a phase does not change the captured sample.
- R10: A sampling edge seen at least one system clock before the word-clock transition belongs to the ending word. An edge seen in the same cycle as the transition, or later, belongs to the new word.
- R11: `smp_ovf` is high with the strobe when the phase just ended had more than 64 sampling edges. It is low for 64 or fewer edges.
- R12: While reset is low, and after it is released, `smp_valid`, `smp_ovf`, `smp_right` and `smp_data` are 0 until the first sample is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = generate link clocks, 0 = accept them |
| cfg_rate | input | 2 | Master divide: 00=256, 01=384, 10/11=512 clocks per frame |
| cfg_fall_edge | input | 1 | 1 = sample data on falling bit-clock edge |
| cfg_left_high | input | 1 | 1 = high word clock marks left |
| cfg_delay | input | 1 | 1 = skip first bit of each phase |
| cfg_rjust | input | 1 | 1 = right-justified capture |
| cfg_res | input | 2 | Right-justified length: 00=24, 01=20, 10=16, 11=24 |
| bclk_i | input | 1 | External bit clock (slave) |
| wclk_i | input | 1 | External word clock (slave) |
| sdin | input | 1 | Serial data |
| bclk_o | output | 1 | Generated bit clock (master) |
| wclk_o | output | 1 | Generated word clock (master) |
| smp_data | output | 24 | Captured sample |
| smp_right | output | 1 | Channel of the sample, 1 = right |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_ovf | output | 1 | Phase exceeded 64 bit clocks |

## Verification
The hardest case to reach is a sampling edge that falls right beside a word-clock transition. Whether that bit belongs to the old word or the new one depends on the exact cycle in which each line clears its synchronizer. The bench drives both lines itself at the system-clock falling edge. It places one sampling edge one system clock ahead of the transition, and another in the same cycle as a transition. The right-justified words captured around those edges then show where each bit went. Gapped bit clocks and exactly-64 versus 65-edge phases are produced the same way, by holding the bit clock idle or by counting the bits sent.

// File: rtl/sai_pkg.sv
`timescale 1ns/1ps
package sai_pkg;
  localparam int SAMPLE_W    = 24;
  localparam int OVF_LIMIT   = 64;
  localparam int CNT_W       = $clog2(2 * OVF_LIMIT);
  localparam int FRAME_BITS  = 64;
  localparam int SYNC_STAGES = 2;
  localparam int HALF_W      = 3;
  localparam int LINK_W      = 3;

  // word length selected for right-justified capture
  function automatic int word_len(logic [1:0] code);
    case (code)
      2'b01:   return 20;
      2'b10:   return 16;
      default: return 24;
    endcase
  endfunction

  // keep the low n bits of the history and sign-extend them
  function automatic logic [SAMPLE_W-1:0] rj_extend(logic [SAMPLE_W-1:0] hist, logic [1:0] code);
    logic [SAMPLE_W-1:0] up;
    int                  sh;
    sh = SAMPLE_W - word_len(code);
    up = hist << sh;
    return SAMPLE_W'($signed(up) >>> sh);
  endfunction

  // system clocks per bit-clock half period
  function automatic logic [HALF_W-1:0] half_len(logic [1:0] rate);
    case (rate)
      2'b00:   return HALF_W'(2);
      2'b01:   return HALF_W'(3);
      default: return HALF_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/sai_clk_gen.sv
`timescale 1ns/1ps
module sai_clk_gen
  import sai_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] rate,
  input  logic       left_high,
  input  logic       fall_edge,
  output logic       bclk_o,
  output logic       wclk_o
);
  localparam int POS_W = $clog2(FRAME_BITS);

  logic [HALF_W-1:0] hcnt;
  logic              bgen;
  logic [POS_W-1:0]  pos;
  logic              wgen;
  logic              half_done;

  assign half_done = (hcnt == half_len(rate) - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      bgen <= 1'b0;
      pos  <= '0;
    end else if (!en) begin
      hcnt <= '0;
      bgen <= 1'b0;
      pos  <= '0;
    end else if (half_done) begin
      hcnt <= '0;
      bgen <= ~bgen;
      if (bgen) pos <= pos + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // first half of the frame is the left channel
  assign wgen   = pos[POS_W-1] ^ left_high;
  assign bclk_o = en & (bgen ^ fall_edge);
  assign wclk_o = en & wgen;

  // R2: every bit-clock level lasts at least two system clocks
  p_bclk_half_r2: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $changed(bgen) |=> $stable(bgen));

  // R2: the word clock moves only together with the non-sampling edge
  p_wclk_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $changed(wgen) |-> $fell(bgen));
endmodule

// File: rtl/sai_sync.sv
`timescale 1ns/1ps
module sai_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  // no reset: the chain tracks the pins during reset so release makes no edge
  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sai_deser.sv
`timescale 1ns/1ps
module sai_deser
  import sai_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall_edge,
  input  logic                left_high,
  input  logic                delay,
  input  logic                rjust,
  input  logic [1:0]          res,
  input  logic                bclk_s,
  input  logic                wclk_s,
  input  logic                sd_s,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_right,
  output logic                smp_valid,
  output logic                smp_ovf
);
  logic                bclk_p, wclk_p;
  logic                bit_edge, word_edge, emit;
  logic [CNT_W-1:0]    cnt, cnt_base, cnt_nxt;
  logic [SAMPLE_W-1:0] acc, acc_nxt, hist, hist_nxt;
  logic                armed;
  int                  bit_idx;

  always_ff @(posedge clk) begin
    bclk_p <= bclk_s;
    wclk_p <= wclk_s;
  end

  assign bit_edge  = fall_edge ? (bclk_p & ~bclk_s) : (~bclk_p & bclk_s);
  assign word_edge = wclk_p ^ wclk_s;
  assign emit      = word_edge & armed;

  // a word-clock change in this cycle opens a new phase before the bit lands
  always_comb begin
    cnt_base = word_edge ? '0 : cnt;
    acc_nxt  = word_edge ? '0 : acc;
    cnt_nxt  = cnt_base;
    hist_nxt = hist;
    bit_idx  = int'(cnt_base) - (delay ? 1 : 0);
    if (bit_edge) begin
      hist_nxt = {hist[SAMPLE_W-2:0], sd_s};
      if (bit_idx >= 0 && bit_idx < SAMPLE_W)
        acc_nxt = acc_nxt | ({{(SAMPLE_W-1){1'b0}}, sd_s} << (SAMPLE_W - 1 - bit_idx));
      if (cnt_base != '1) cnt_nxt = cnt_base + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      acc       <= '0;
      hist      <= '0;
      armed     <= 1'b0;
      smp_data  <= '0;
      smp_right <= 1'b0;
      smp_valid <= 1'b0;
      smp_ovf   <= 1'b0;
    end else begin
      cnt       <= cnt_nxt;
      acc       <= acc_nxt;
      hist      <= hist_nxt;
      smp_valid <= emit;
      smp_ovf   <= emit & (cnt > CNT_W'(OVF_LIMIT));
      if (word_edge) armed <= 1'b1;
      if (emit) begin
        smp_data  <= rjust ? rj_extend(hist, res) : acc;
        smp_right <= wclk_p ^ left_high;
      end
    end
  end

  // R8: strobe lasts one cycle
  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  // R8: nothing is emitted before the arming transition
  p_silent_until_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !smp_valid);

  // R11: the overflow flag only accompanies a strobe
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ovf |-> smp_valid);

  // R9: a detected sampling edge is a single-cycle event
  p_edge_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_edge |=> !bit_edge);
endmodule

// File: rtl/sai_rx_port.sv
`timescale 1ns/1ps
module sai_rx_port
  import sai_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_master,
  input  logic [1:0]          cfg_rate,
  input  logic                cfg_fall_edge,
  input  logic                cfg_left_high,
  input  logic                cfg_delay,
  input  logic                cfg_rjust,
  input  logic [1:0]          cfg_res,
  input  logic                bclk_i,
  input  logic                wclk_i,
  input  logic                sdin,
  output logic                bclk_o,
  output logic                wclk_o,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_right,
  output logic                smp_valid,
  output logic                smp_ovf
);
  logic              bclk_src, wclk_src;
  logic [LINK_W-1:0] link_raw, link_s;

  sai_clk_gen u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_master),
    .rate      (cfg_rate),
    .left_high (cfg_left_high),
    .fall_edge (cfg_fall_edge),
    .bclk_o    (bclk_o),
    .wclk_o    (wclk_o)
  );

  assign bclk_src = cfg_master ? bclk_o : bclk_i;
  assign wclk_src = cfg_master ? wclk_o : wclk_i;
  assign link_raw = {bclk_src, wclk_src, sdin};

  sai_sync #(.W(LINK_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (link_raw),
    .q   (link_s)
  );

  sai_deser u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_edge (cfg_fall_edge),
    .left_high (cfg_left_high),
    .delay     (cfg_delay),
    .rjust     (cfg_rjust),
    .res       (cfg_res),
    .bclk_s    (link_s[2]),
    .wclk_s    (link_s[1]),
    .sd_s      (link_s[0]),
    .smp_data  (smp_data),
    .smp_right (smp_right),
    .smp_valid (smp_valid),
    .smp_ovf   (smp_ovf)
  );
endmodule

// File: tb/sai_rx_port_test.sv
`timescale 1ns/1ps
module sai_rx_port_test;
  localparam int HB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b0, cfg_fall_edge = 1'b0, cfg_left_high = 1'b0;
  logic cfg_delay = 1'b0, cfg_rjust = 1'b0;
  logic [1:0] cfg_rate = 2'b00, cfg_res = 2'b00;
  logic bclk_i = 1'b0, wclk_i = 1'b1, sdin = 1'b0;
  logic bclk_o, wclk_o, smp_right, smp_valid, smp_ovf;
  logic [23:0] smp_data;

  int total = 0, bad = 0, ncap = 0;
  logic [23:0] cap_d [64];
  logic        cap_r [64];
  logic        cap_o [64];

  always #2 clk = ~clk;

  sai_rx_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_rate(cfg_rate),
    .cfg_fall_edge(cfg_fall_edge), .cfg_left_high(cfg_left_high), .cfg_delay(cfg_delay),
    .cfg_rjust(cfg_rjust), .cfg_res(cfg_res), .bclk_i(bclk_i), .wclk_i(wclk_i),
    .sdin(sdin), .bclk_o(bclk_o), .wclk_o(wclk_o), .smp_data(smp_data),
    .smp_right(smp_right), .smp_valid(smp_valid), .smp_ovf(smp_ovf)
  );

  always @(negedge clk)
    if (rst_n && smp_valid && ncap < 64) begin
      cap_d[ncap] = smp_data;
      cap_r[ncap] = smp_right;
      cap_o[ncap] = smp_ovf;
      ncap = ncap + 1;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_reset();
    rst_n  = 1'b0;
    wclk_i = ~cfg_left_high;
    bclk_i = cfg_fall_edge;
    sdin   = 1'b0;
    tick(6);
    rst_n = 1'b1;
    tick(4);
    ncap = 0;
  endtask

  task automatic bit_out(input logic b);
    bclk_i = cfg_fall_edge;
    sdin   = b;
    tick(HB);
    bclk_i = ~cfg_fall_edge;
    tick(HB);
    bclk_i = cfg_fall_edge;
  endtask

  task automatic send(input logic [127:0] v, input int n, input int gap);
    for (int i = n - 1; i >= 0; i--) begin
      bit_out(v[i]);
      if (gap > 0 && (i % 4) == 0) tick(gap);
    end
  endtask

  task automatic set_w(input logic l);
    wclk_i = l;
    tick(2);
  endtask

  task automatic run_pair(input logic [127:0] lv, input int ln, input logic [127:0] rv,
                          input int rn, input int gap);
    set_w(cfg_left_high);
    send(lv, ln, gap);
    set_w(~cfg_left_high);
    send(rv, rn, gap);
    set_w(cfg_left_high);
    tick(8);
  endtask

  task automatic expect_cap(input string req, input int idx, input logic [23:0] d,
                            input logic r, input logic o);
    if (idx >= ncap) begin
      chk({req, " missing sample"}, ncap, idx + 1);
    end else begin
      chk({req, " data"}, cap_d[idx], d);
      chk({req, " channel"}, cap_r[idx], r);
      chk({req, " overflow"}, cap_o[idx], o);
    end
  endtask

  task automatic set_cfg(input logic m, input logic fe, input logic lh, input logic dl,
                         input logic rj, input logic [1:0] rs);
    cfg_master = m; cfg_fall_edge = fe; cfg_left_high = lh;
    cfg_delay = dl; cfg_rjust = rj; cfg_res = rs;
    tick(2);
  endtask

  // R12 R1: reset values, clock outputs low in slave mode
  task automatic t_reset();
    set_cfg(0, 0, 0, 0, 0, 2'b00);
    rst_n = 1'b0;
    tick(3);
    chk("R12 valid in reset", smp_valid, 0);
    apply_reset();
    chk("R12 data", smp_data, 0);
    chk("R12 valid", smp_valid, 0);
    chk("R12 ovf", smp_ovf, 0);
    chk("R12 right", smp_right, 0);
    chk("R1 bclk_o slave", bclk_o, 0);
    chk("R1 wclk_o slave", wclk_o, 0);
  endtask

  // R6 R8: left-justified 24-bit pair, arming transition emits nothing
  task automatic t_lj24();
    set_cfg(0, 0, 0, 0, 0, 2'b00);
    apply_reset();
    set_w(1'b0);
    tick(10);
    chk("R8 arming emits nothing", ncap, 0);
    send(24'h123456, 24, 0);
    set_w(1'b1);
    send(24'hABCDEF, 24, 0);
    set_w(1'b0);
    tick(8);
    chk("R8 sample count", ncap, 2);
    expect_cap("R6 lj left", 0, 24'h123456, 0, 0);
    expect_cap("R6 lj right", 1, 24'hABCDEF, 1, 0);
    chk("R8 data held", smp_data, 24'hABCDEF);
    chk("R1 bclk_o stays low", bclk_o, 0);
  endtask

  // R5: one-bit delay skips the first bit
  task automatic t_i2s();
    set_cfg(0, 0, 0, 1, 0, 2'b00);
    apply_reset();
    run_pair({1'b1, 24'h0F1E2D, 7'h7F}, 32, {1'b0, 24'hF0E1D2, 7'h00}, 32, 0);
    expect_cap("R5 delay left", 0, 24'h0F1E2D, 0, 0);
    expect_cap("R5 delay right", 1, 24'hF0E1D2, 1, 0);
  endtask

  // R6: short word padded, long word truncated
  task automatic t_lj_len();
    set_cfg(0, 0, 0, 0, 0, 2'b00);
    apply_reset();
    run_pair(16'hBEEF, 16, {24'h13579B, 6'h3F}, 30, 0);
    expect_cap("R6 short word", 0, 24'hBEEF00, 0, 0);
    expect_cap("R6 long word", 1, 24'h13579B, 1, 0);
  endtask

  // R7: right-justified with each resolution code
  task automatic t_rj();
    set_cfg(0, 0, 0, 0, 1, 2'b10);
    apply_reset();
    run_pair({16'hFFFF, 16'h8123}, 32, {16'hAAAA, 16'h7ABC}, 32, 0);
    expect_cap("R7 rj16 negative", 0, 24'hFF8123, 0, 0);
    expect_cap("R7 rj16 positive", 1, 24'h007ABC, 1, 0);
    set_cfg(0, 0, 0, 0, 1, 2'b01);
    apply_reset();
    run_pair({12'h555, 20'h80001}, 32, {12'hFFF, 20'h7FFFE}, 32, 0);
    expect_cap("R7 rj20 negative", 0, 24'hF80001, 0, 0);
    expect_cap("R7 rj20 positive", 1, 24'h07FFFE, 1, 0);
    set_cfg(0, 0, 0, 0, 1, 2'b11);
    apply_reset();
    run_pair({8'hFF, 24'h654321}, 32, {8'h00, 24'h9ABCDE}, 32, 0);
    expect_cap("R7 rj code 11 is 24", 0, 24'h654321, 0, 0);
    expect_cap("R7 rj code 11 is 24", 1, 24'h9ABCDE, 1, 0);
  endtask

  // R3 R4: falling-edge sampling, high word clock is left
  task automatic t_polarity();
    set_cfg(0, 1, 1, 0, 0, 2'b00);
    apply_reset();
    run_pair(24'h2468AC, 24, 24'h13579B, 24, 0);
    expect_cap("R3 falling edge left", 0, 24'h2468AC, 0, 0);
    expect_cap("R4 high is left, right flag", 1, 24'h13579B, 1, 0);
  endtask

  // R9: long stalls of the bit clock inside a phase
  task automatic t_gap();
    set_cfg(0, 0, 0, 0, 0, 2'b00);
    apply_reset();
    run_pair(24'hC71D39, 24, 24'h5E0F3A, 24, 150);
    expect_cap("R9 gapped left", 0, 24'hC71D39, 0, 0);
    expect_cap("R9 gapped right", 1, 24'h5E0F3A, 1, 0);
  endtask

  // R10: edges next to a word-clock transition
  task automatic t_boundary();
    set_cfg(0, 0, 0, 0, 1, 2'b00);
    apply_reset();
    set_w(1'b0);
    send(23'h1E1E1E, 23, 0);
    bclk_i = 1'b0; sdin = 1'b1; tick(HB);
    bclk_i = 1'b1; tick(1);
    wclk_i = 1'b1; tick(HB);
    bclk_i = 1'b0; tick(HB);
    send(24'h5A5A5A, 24, 0);
    bclk_i = 1'b0; sdin = 1'b1; tick(HB);
    bclk_i = 1'b1; wclk_i = 1'b0; tick(HB);
    bclk_i = 1'b0;
    send(23'h000001, 23, 0);
    set_w(1'b1);
    tick(8);
    expect_cap("R10 early edge joins old word", 0, 24'h3C3C3D, 0, 0);
    expect_cap("R10 coincident edge leaves old word", 1, 24'h5A5A5A, 1, 0);
    expect_cap("R10 coincident edge starts new word", 2, 24'h800001, 0, 0);
  endtask

  // R11: 65 edges overflow, 64 do not
  task automatic t_ovf();
    set_cfg(0, 0, 0, 0, 0, 2'b00);
    apply_reset();
    run_pair({24'hC3A5F0, 41'h0}, 65, {24'h0FF0AA, 40'h0}, 64, 0);
    expect_cap("R11 65 edges", 0, 24'hC3A5F0, 0, 1);
    expect_cap("R11 64 edges", 1, 24'h0FF0AA, 1, 0);
  endtask

  // R2: generated clock timing for one rate code
  task automatic t_master_clk(input logic [1:0] rate, input int half);
    int hi, lo;
    cfg_rate = rate;
    set_cfg(1, 0, 0, 0, 0, 2'b00);
    apply_reset();
    while (bclk_o !== 1'b0) tick(1);
    while (bclk_o !== 1'b1) tick(1);
    hi = 0; while (bclk_o === 1'b1) begin tick(1); hi++; end
    lo = 0; while (bclk_o === 1'b0) begin tick(1); lo++; end
    chk("R2 bclk high time", hi, half);
    chk("R2 bclk low time", lo, half);
    while (wclk_o !== 1'b0) tick(1);
    while (wclk_o !== 1'b1) tick(1);
    hi = 0; while (wclk_o === 1'b1) begin tick(1); hi++; end
    lo = 0; while (wclk_o === 1'b0) begin tick(1); lo++; end
    chk("R2 wclk high time", hi, 64 * half);
    chk("R2 wclk low time", lo, 64 * half);
  endtask

  // R1: master mode capture with data following the generated clocks
  task automatic t_master_data();
    int pos;
    logic pb, pw;
    logic [23:0] w;
    cfg_rate = 2'b00;
    set_cfg(1, 0, 0, 0, 0, 2'b00);
    apply_reset();
    bclk_i = 1'b1; wclk_i = 1'b0;
    pos = 99; pb = bclk_o; pw = wclk_o;
    for (int c = 0; c < 1200; c++) begin
      @(negedge clk);
      if (wclk_o != pw) pos = 0;
      else if (pb && !bclk_o) pos++;
      w = (wclk_o == cfg_left_high) ? 24'hC0FFEE : 24'h5A5A5A;
      sdin = (pos < 24) ? w[23 - pos] : 1'b0;
      pb = bclk_o; pw = wclk_o;
    end
    expect_cap("R1 master right", 0, 24'h5A5A5A, 1, 0);
    expect_cap("R1 master left", 1, 24'hC0FFEE, 0, 0);
    expect_cap("R1 master right again", 2, 24'h5A5A5A, 1, 0);
    expect_cap("R1 master left again", 3, 24'hC0FFEE, 0, 0);
  endtask

  initial begin
    #600000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_lj24();
    t_i2s();
    t_lj_len();
    t_rj();
    t_polarity();
    t_gap();
    t_boundary();
    t_ovf();
    t_master_clk(2'b00, 2);
    t_master_clk(2'b01, 3);
    t_master_clk(2'b10, 4);
    t_master_clk(2'b11, 4);
    t_master_data();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule